// File: doc/BRIEF.md
# Activity and Link LED Controller

This block turns link status and single-cycle traffic events into two active-low indicator outputs. The activity output follows one of four behaviours chosen by a 2-bit mode input. It can blink on receive traffic only, on transmit traffic only, or on either. In the fourth mode it shows link state, and traffic on a live link interrupts the steady-on state with blinks. The status output shows whether the infrastructure link is up.

All timing is counted in ticks. A free-running prescaler produces one tick every `TICK_DIV` clocks. The default tick is 1 ms at a 125 MHz clock, and the defaults of `DARK_TICKS` and `LIT_TICKS` give the 100 ms off period and the 12 ms on period. For simulation, all three parameters are made small. A blink is an off period followed by an on period. Traffic that arrives while a blink is running is remembered, so the next blink follows without a gap. A mode change, or loss of link in the link mode, stops any blink at once.

Top module: `led_status_ctl`

## Requirements
- R1: During reset and after it, both outputs are high (LED off). In modes 2'b00, 2'b01 and 2'b10, with no qualifying event, `led_act_n` stays high.
- R2: A tick occurs on every `TICK_DIV`-th clock after reset is released. All phase lengths are counted in ticks.
- R3: A latched event starts a blink on the next tick. `led_act_n` is then high for `DARK_TICKS` ticks and low for `LIT_TICKS` ticks. By default this is 100 and 12 ticks of 1 ms each.
- R4: Mode 2'b00 reacts only to `rx_evt`, mode 2'b01 only to `tx_evt`, and mode 2'b10 to either. An event on the unselected input changes nothing.
- R5: In mode 2'b11, `led_act_n` is high while `link_up` is 0 and low while the link is up and no blink is running. Events on a live link run the same blink.
- R6: `led_stat_n` is low exactly while `infra_up` is 1.
- R7: Events that arrive during a blink are held as one pending request. When the low period ends and a request is pending, the next high period starts on that same tick, with no idle tick in between. Several events collapse into one extra blink.
- R8: A change of `mode`, or `link_up` at 0 in mode 2'b11, returns `led_act_n` to its idle level at the next clock edge and drops any pending request.
- R9: An event in the same clock as the tick that consumes the pending request stays latched and produces a further blink.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Activity behaviour select (00 rx, 01 tx, 10 either, 11 link with traffic) |
| link_up | input | 1 | Link established |
| infra_up | input | 1 | Infrastructure link established |
| rx_evt | input | 1 | One-clock receive event |
| tx_evt | input | 1 | One-clock transmit event |
| led_act_n | output | 1 | Activity LED, active low |
| led_stat_n | output | 1 | Infrastructure link LED, active low |

## Verification
Two functions can coincide in one clock: the tick that consumes the pending request and starts a blink, and a fresh traffic event. The bench provokes this by using its own tick count to place a `tx_evt` pulse exactly on the consuming edge. It then requires a second blink whose high period starts on the same tick that ends the first low period. The same model judges a mode change or link loss landing in the middle of a blink, on every clock.

// File: rtl/led_ctl_pkg.sv
// Shared types for the activity/link LED controller.
// Assumes the mode encoding below is fixed by the register that drives it.
package led_ctl_pkg;
    typedef enum logic [1:0] {
        LM_RX   = 2'b00,
        LM_TX   = 2'b01,
        LM_BOTH = 2'b10,
        LM_LINK = 2'b11
    } led_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_DARK = 2'b01,
        PH_LIT  = 2'b10
    } led_phase_e;
endpackage

// File: rtl/led_tick_gen.sv
// Free-running prescaler: one-clock tick every TICK_DIV clocks.
// Assumes TICK_DIV >= 1; the first tick comes TICK_DIV clocks after reset.
module led_tick_gen #(
    parameter int TICK_DIV = 125000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CW-1:0] cnt_q;

    // Terminal count marks the tick.
    assign tick_o = (cnt_q == CW'(TICK_DIV - 1));

    // Count clocks, wrap on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/led_evt_qualify.sv
// Picks the traffic events that count in the current mode, flags aborts
// (mode change, or link lost in link mode) and gives the idle LED level.
// Assumes rx/tx events are single-clock pulses synchronous to clk.
module led_evt_qualify
    import led_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  led_mode_e mode_i,
    input  logic      link_i,
    input  logic      rx_i,
    input  logic      tx_i,
    output logic      act_o,
    output logic      abort_o,
    output logic      idle_lit_o
);
    led_mode_e mode_q;

    // Remember last clock's mode to see a change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= LM_RX;
        end else begin
            mode_q <= mode_i;
        end
    end

    // Event selection by mode.
    always_comb begin
        unique case (mode_i)
            LM_RX:   act_o = rx_i;
            LM_TX:   act_o = tx_i;
            default: act_o = rx_i | tx_i;
        endcase
    end

    // Abort and idle level.
    always_comb begin
        abort_o    = (mode_i != mode_q) || ((mode_i == LM_LINK) && !link_i);
        idle_lit_o = (mode_i == LM_LINK) && link_i;
    end
endmodule

// File: rtl/led_blink_seq.sv
// Blink sequencer: on a tick with a pending request it runs DARK_TICKS ticks
// of LED-off then LIT_TICKS ticks of LED-on; a request pending at the end of
// the lit phase restarts the dark phase on the same tick.
// Assumes DARK_TICKS and LIT_TICKS are at least 1.
module led_blink_seq
    import led_ctl_pkg::*;
#(
    parameter int DARK_TICKS = 100,
    parameter int LIT_TICKS  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic act_i,
    input  logic abort_i,
    output logic dark_o,
    output logic lit_o
);
    localparam int MAXT = (DARK_TICKS > LIT_TICKS) ? DARK_TICKS : LIT_TICKS;
    localparam int RW   = (MAXT > 1) ? $clog2(MAXT) : 1;
    localparam logic [RW-1:0] DARK_LAST = RW'(DARK_TICKS - 1);
    localparam logic [RW-1:0] LIT_LAST  = RW'(LIT_TICKS - 1);

    led_phase_e    phase_q, phase_d;
    logic [RW-1:0] rem_q, rem_d;
    logic          pend_q, pend_d;
    logic          consume;

    // Next phase, remaining ticks and pending request.
    always_comb begin
        phase_d = phase_q;
        rem_d   = rem_q;
        consume = 1'b0;
        if (tick_i) begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (pend_q) begin
                        phase_d = PH_DARK;
                        rem_d   = DARK_LAST;
                        consume = 1'b1;
                    end
                end
                PH_DARK: begin
                    if (rem_q == '0) begin
                        phase_d = PH_LIT;
                        rem_d   = LIT_LAST;
                    end else begin
                        rem_d = rem_q - 1'b1;
                    end
                end
                PH_LIT: begin
                    if (rem_q != '0) begin
                        rem_d = rem_q - 1'b1;
                    end else if (pend_q) begin
                        phase_d = PH_DARK;
                        rem_d   = DARK_LAST;
                        consume = 1'b1;
                    end else begin
                        phase_d = PH_IDLE;
                        rem_d   = '0;
                    end
                end
                default: begin
                    phase_d = PH_IDLE;
                    rem_d   = '0;
                end
            endcase
        end
        pend_d = (pend_q && !consume) || act_i;
        if (abort_i) begin
            phase_d = PH_IDLE;
            rem_d   = '0;
            pend_d  = 1'b0;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            rem_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            rem_q   <= rem_d;
            pend_q  <= pend_d;
        end
    end

    // Phase flags for the output mux.
    assign dark_o = (phase_q == PH_DARK);
    assign lit_o  = (phase_q == PH_LIT);
endmodule

// File: rtl/led_status_ctl.sv
// Top: activity LED per 2-bit mode plus infrastructure link LED, both
// active low. Assumes event inputs are synchronous single-clock pulses.
module led_status_ctl
    import led_ctl_pkg::*;
#(
    parameter int TICK_DIV   = 125000,
    parameter int DARK_TICKS = 100,
    parameter int LIT_TICKS  = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       link_up,
    input  logic       infra_up,
    input  logic       rx_evt,
    input  logic       tx_evt,
    output logic       led_act_n,
    output logic       led_stat_n
);
    logic tick;
    logic act;
    logic abort;
    logic idle_lit;
    logic blink_dark;
    logic blink_lit;

    led_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    led_evt_qualify qual_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (led_mode_e'(mode)),
        .link_i     (link_up),
        .rx_i       (rx_evt),
        .tx_i       (tx_evt),
        .act_o      (act),
        .abort_o    (abort),
        .idle_lit_o (idle_lit)
    );

    led_blink_seq #(.DARK_TICKS(DARK_TICKS), .LIT_TICKS(LIT_TICKS)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .act_i   (act),
        .abort_i (abort),
        .dark_o  (blink_dark),
        .lit_o   (blink_lit)
    );

    // Activity LED: blink phases override the idle level.
    always_comb begin
        if (blink_lit) begin
            led_act_n = 1'b0;
        end else if (blink_dark) begin
            led_act_n = 1'b1;
        end else begin
            led_act_n = !idle_lit;
        end
    end

    // Infrastructure LED lit while that link is up.
    assign led_stat_n = !infra_up;
endmodule

// File: rtl/led_status_ctl_chk.sv
// Checker for led_status_ctl, attached by bind. Tick spacing and phase
// lengths are tracked with counters rather than deep $past.
module led_status_ctl_chk #(
    parameter int TICK_DIV   = 125000,
    parameter int DARK_TICKS = 100,
    parameter int LIT_TICKS  = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       abort,
    input logic       blink_dark,
    input logic       blink_lit,
    input logic [1:0] mode,
    input logic       link_up,
    input logic       infra_up,
    input logic       led_act_n,
    input logic       led_stat_n
);
    int gap_q;
    int dark_q;
    int lit_q;

    // Clocks since last tick, ticks in each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= 0;
            dark_q <= 0;
            lit_q  <= 0;
        end else begin
            gap_q  <= tick ? 0 : gap_q + 1;
            dark_q <= !blink_dark ? 0 : (tick ? dark_q + 1 : dark_q);
            lit_q  <= !blink_lit ? 0 : (tick ? lit_q + 1 : lit_q);
        end
    end

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q == TICK_DIV - 1));

    a_r3_dark_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_dark && tick && !abort && dark_q < DARK_TICKS - 1) |=> blink_dark);

    a_r3_dark_to_lit: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_dark && tick && !abort && dark_q == DARK_TICKS - 1) |=> blink_lit);

    a_r3_lit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_lit && tick && !abort && lit_q < LIT_TICKS - 1) |=> blink_lit);

    a_r3_lit_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_lit && tick && !abort && lit_q == LIT_TICKS - 1) |=> !blink_lit);

    a_r5_nolink_dark: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b11 && !$past(link_up) && mode == 2'b11 && !link_up)
        |-> led_act_n);

    a_r6_stat_follows: assert property (@(posedge clk) disable iff (!rst_n)
        led_stat_n == !infra_up);

    a_r8_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!blink_dark && !blink_lit));
endmodule

bind led_status_ctl led_status_ctl_chk #(
    .TICK_DIV   (TICK_DIV),
    .DARK_TICKS (DARK_TICKS),
    .LIT_TICKS  (LIT_TICKS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .abort      (abort),
    .blink_dark (blink_dark),
    .blink_lit  (blink_lit),
    .mode       (mode),
    .link_up    (link_up),
    .infra_up   (infra_up),
    .led_act_n  (led_act_n),
    .led_stat_n (led_stat_n)
);

// File: tb/led_status_ctl_tb_top.sv
module led_status_ctl_tb_top;
    localparam int DIV  = 3;
    localparam int DARK = 4;
    localparam int LIT  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       link_up = 1'b0;
    logic       infra_up = 1'b0;
    logic       rx_evt = 1'b0;
    logic       tx_evt = 1'b0;
    logic       led_act_n;
    logic       led_stat_n;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Behavioural reference state (0 idle, 1 dark, 2 lit).
    int m_cnt = 0, m_st = 0, m_rem = 0, m_pend = 0, m_prev = 0;

    always #4 clk = !clk;

    led_status_ctl #(.TICK_DIV(DIV), .DARK_TICKS(DARK), .LIT_TICKS(LIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .link_up(link_up),
        .infra_up(infra_up), .rx_evt(rx_evt), .tx_evt(tx_evt),
        .led_act_n(led_act_n), .led_stat_n(led_stat_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model update on each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_st = 0; m_rem = 0; m_pend = 0; m_prev = 0;
        end else begin
            int  old_pend;
            bit  tk, ab, q;
            int  take;
            tk = (m_cnt == DIV - 1);
            m_cnt = tk ? 0 : m_cnt + 1;
            ab = (int'(mode) != m_prev) || (mode == 2'b11 && !link_up);
            q  = (mode == 2'b00) ? rx_evt : (mode == 2'b01) ? tx_evt : (rx_evt | tx_evt);
            old_pend = m_pend;
            take = 0;
            if (ab) begin
                m_st = 0; m_rem = 0; m_pend = 0;
            end else begin
                if (tk) begin
                    if (m_st == 0) begin
                        if (old_pend != 0) begin m_st = 1; m_rem = DARK; take = 1; end
                    end else if (m_st == 1) begin
                        m_rem--;
                        if (m_rem == 0) begin m_st = 2; m_rem = LIT; end
                    end else begin
                        m_rem--;
                        if (m_rem == 0) begin
                            if (old_pend != 0) begin m_st = 1; m_rem = DARK; take = 1; end
                            else m_st = 0;
                        end
                    end
                end
                m_pend = ((old_pend != 0) && take == 0) || q ? 1 : 0;
            end
            m_prev = int'(mode);
        end
    end

    function automatic int exp_act();
        if (m_st == 2) return 0;
        if (m_st == 1) return 1;
        return (mode == 2'b11 && link_up) ? 0 : 1;
    endfunction

    // Compare against the model every clock, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(led_act_n == exp_act(), cur_req, "led_act_n vs model", led_act_n, exp_act());
            check(led_stat_n == !infra_up, "R6", "led_stat_n vs model", led_stat_n, !infra_up);
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic pulse_rx(); rx_evt = 1'b1; step(1); rx_evt = 1'b0; endtask
    task automatic pulse_tx(); tx_evt = 1'b1; step(1); tx_evt = 1'b0; endtask

    // Cycles until led_act_n reaches level v (capped).
    task automatic wait_level(input bit v, output int n);
        n = 0;
        while (led_act_n != v && n < 500) begin step(1); n++; end
    endtask

    // Cycles led_act_n stays at level v (capped).
    task automatic hold_len(input bit v, output int n);
        n = 0;
        while (led_act_n == v && n < 500) begin step(1); n++; end
    endtask

    // Level stays v for n cycles.
    task automatic steady(input bit v, input int n, input string req, input string what);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (led_act_n != v) bad++;
            step(1);
        end
        check(bad == 0, req, what, bad, 0);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode = m; step(2);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n, m;
        // R1 reset state
        step(3);
        check(led_act_n == 1'b1, "R1", "act during reset", led_act_n, 1);
        check(led_stat_n == 1'b1, "R1", "stat during reset", led_stat_n, 1);
        rst_n = 1'b1;
        step(1);
        cur_req = "R1";
        steady(1'b1, 20, "R1", "idle high without events");

        // R6 infrastructure LED
        infra_up = 1'b1; step(1);
        check(led_stat_n == 1'b0, "R6", "stat lit with infra link", led_stat_n, 0);
        infra_up = 1'b0; step(1);
        check(led_stat_n == 1'b1, "R6", "stat dark without infra link", led_stat_n, 1);

        // R3 / R2 blink shape in rx mode
        cur_req = "R3";
        pulse_rx();
        wait_level(1'b0, n);
        check(n >= DARK * DIV && n <= (DARK + 1) * DIV, "R3", "dark period before lit",
              n, DARK * DIV);
        hold_len(1'b0, m);
        check(m == LIT * DIV, "R2", "lit period in clocks", m, LIT * DIV);
        steady(1'b1, (DARK + LIT + 2) * DIV, "R3", "single blink then idle");

        // R4 unselected inputs ignored
        cur_req = "R4";
        pulse_tx();
        steady(1'b1, (DARK + LIT + 2) * DIV, "R4", "tx ignored in rx mode");
        set_mode(2'b01);
        pulse_rx();
        steady(1'b1, (DARK + LIT + 2) * DIV, "R4", "rx ignored in tx mode");
        pulse_tx();
        wait_level(1'b0, n);
        check(n < (DARK + 2) * DIV, "R4", "tx blinks in tx mode", n, DARK * DIV);
        step(LIT * DIV + DIV);
        set_mode(2'b10);
        pulse_rx();
        wait_level(1'b0, n);
        check(n < (DARK + 2) * DIV, "R4", "rx blinks in either mode", n, DARK * DIV);
        step(LIT * DIV + DIV);
        pulse_tx();
        wait_level(1'b0, n);
        check(n < (DARK + 2) * DIV, "R4", "tx blinks in either mode", n, DARK * DIV);
        step(LIT * DIV + DIV);

        // R7 pending requests chain directly, several collapse
        cur_req = "R7";
        set_mode(2'b00);
        pulse_rx();
        wait_level(1'b0, n);
        pulse_rx(); pulse_rx(); pulse_rx();
        hold_len(1'b0, m);
        hold_len(1'b1, n);
        check(n == DARK * DIV, "R7", "chained dark period", n, DARK * DIV);
        hold_len(1'b0, m);
        steady(1'b1, (DARK + LIT + 2) * DIV, "R7", "events collapse to one extra blink");

        // R5 link mode
        cur_req = "R5";
        link_up = 1'b0;
        set_mode(2'b11);
        check(led_act_n == 1'b1, "R5", "no link dark", led_act_n, 1);
        pulse_rx();
        steady(1'b1, (DARK + 2) * DIV, "R5", "events ignored without link");
        link_up = 1'b1; step(1);
        check(led_act_n == 1'b0, "R5", "link idle lit", led_act_n, 0);
        pulse_tx();
        wait_level(1'b1, n);
        hold_len(1'b1, m);
        check(m == DARK * DIV, "R5", "traffic dark period on link", m, DARK * DIV);
        step(LIT * DIV + DIV);
        check(led_act_n == 1'b0, "R5", "back to lit after blink", led_act_n, 0);

        // R8 abort on link loss and on mode change
        cur_req = "R8";
        pulse_rx(); pulse_rx();
        wait_level(1'b1, n);
        link_up = 1'b0; step(1);
        check(led_act_n == 1'b1, "R8", "link loss idles", led_act_n, 1);
        link_up = 1'b1; step(1);
        steady(1'b0, (DARK + LIT + 2) * DIV, "R8", "pending dropped on link loss");
        set_mode(2'b00);
        pulse_rx();
        wait_level(1'b0, n);
        pulse_rx();
        mode = 2'b01; step(1);
        check(led_act_n == 1'b1, "R8", "mode change idles", led_act_n, 1);
        steady(1'b1, (DARK + LIT + 2) * DIV, "R8", "pending dropped on mode change");

        // R9 event on the consuming tick
        cur_req = "R9";
        pulse_tx();
        while (m_cnt != DIV - 1) step(1);
        tx_evt = 1'b1; step(1); tx_evt = 1'b0;
        check(led_act_n == 1'b1, "R9", "blink started on tick", led_act_n, 1);
        wait_level(1'b0, n);
        hold_len(1'b0, m);
        hold_len(1'b1, n);
        check(n == DARK * DIV, "R9", "coincident event gives second blink", n, DARK * DIV);
        hold_len(1'b0, m);
        check(m == LIT * DIV, "R9", "second lit period", m, LIT * DIV);
        steady(1'b1, (DARK + LIT + 2) * DIV, "R9", "no third blink");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule